// File: doc/BRIEF.md
# Debug Bus Word Access Sequencer

This block carries out a single 32-bit read or write on a target bus that sits behind a scan-based debug module. A request (`start` with direction, address and write data) is turned into two data-register scans. The first is a command frame that names the access. The second is a GO frame that moves the data. Each frame is handed to a generic scan port as a 128-bit vector plus a bit length. When the scan completes, the port returns the captured reply vector. The sequencer checks the status and CRC of every reply and reissues a phase that fails.

Bit `i` of a frame or reply vector is the `i`-th bit shifted, counting from 0. A "reversed" field of width W at offset O puts value bit W-1-k at vector bit O+k. The CRC starts at all ones. For each bit `d` taken in ascending vector order, it shifts left one place and XORs in polynomial 0x04C11DB7 when `d` XOR the old bit 31 is 1. No final inversion is applied. Every CRC field is sent reversed.

The state machine has six states:
- `S_IDLE` goes to `S_CMD_REQ` on `start`.
- `S_CMD_REQ` goes to `S_CMD_WAIT` when `scan_ready` is high.
- `S_CMD_WAIT`, on `scan_done`, goes to `S_GO_REQ` if the reply is good. Otherwise it goes back to `S_CMD_REQ` (retry), or to `S_DONE` once the retry limit is reached.
- `S_GO_REQ` goes to `S_GO_WAIT` when `scan_ready` is high.
- `S_GO_WAIT`, on `scan_done`, goes to `S_DONE` on success, on a read abort, or at the retry limit. Otherwise it goes back to `S_GO_REQ`.
- `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `dbgw_seq`

## Requirements
- R1: After reset, `done`, `error` and `scan_valid` are low and `rdata` is zero.
- R2: The command frame has length 125. It holds a zero bit 0, opcode 0x2 reversed in bits 1..4, access type reversed in bits 5..8 (0x6 for read, 0x2 for write), the address reversed in bits 9..40, and value 3 reversed in bits 41..56. Bits 57..88 hold the CRC of bits 0..56, reversed. All higher bits are zero.
- R3: The GO frame has length 105, with bits 0..4 zero. For a read, bits 5..36 hold the reversed CRC of bits 0..4. For a write, bits 5..36 hold the write data reversed and bits 37..68 hold the reversed CRC of bits 0..36. All higher bits are zero.
- R4: A command reply is good when status bits 89..92 are zero and the reversed field at 93..124 equals the CRC of bits 89..92. Otherwise the same command frame is issued again.
- R5: A read GO reply carries data reversed in bits 37..68, status reversed in 69..72, and the reversed CRC of bits 37..72 in 73..104. On a CRC mismatch with zero status the GO frame is reissued. On success `rdata` takes the data and `error` stays low.
- R6: A read GO reply with nonzero status and a valid CRC ends the access at once, with `error` high and `rdata` zero, and issues no further scan.
- R7: A write GO reply is good when status bits 69..72 are zero and the reversed field at 73..104 equals the CRC of bits 69..72. Otherwise the GO frame is reissued.
- R8: A phase is tried at most MAX_TRIES times. If the last try fails, the access ends with `error` high and `rdata` zero, and no later phase is issued.
- R9: While `scan_valid` is high and `scan_ready` is low, the frame and length hold steady. After a frame is accepted, no new frame is offered before `scan_done`.
- R10: `done` is a single-cycle pulse, one per accepted request.
- R11: `start` raised while an access is in progress is ignored. The running access keeps its latched address, direction and data, and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken in idle only |
| is_write | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Target word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read result, zero after error or write |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Access failed, valid with done |
| scan_valid | output | 1 | Frame offered to the scan port |
| scan_ready | input | 1 | Scan port accepts the frame |
| scan_frame | output | 128 | Frame bits, bit 0 shifted first |
| scan_len | output | 7 | Scan length in bits |
| scan_done | input | 1 | Reply vector is valid |
| scan_reply | input | 128 | Captured reply bits |

## Verification
`scan_valid` rises one cycle after `start` is sampled. After each accepted frame, the next phase's frame is offered one cycle after its `scan_done` is sampled. `done`, `rdata` and `error` appear one cycle after the final `scan_done`. The bench acts as the scan port and drives inputs at falling edges. It checks each offered frame before it raises `scan_ready`, including one cycle of back-pressure. A monitor compares the result fields and the per-phase attempt counts against a queued expectation on the falling edge where `done` is high. The driver then confirms that `done` has dropped one falling edge later.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
    localparam int FRAME_W = 128;
    localparam int LEN_W   = 7;
    localparam int WORD_W  = 32;

    localparam logic [LEN_W-1:0] CMD_LEN = 7'd125;
    localparam logic [LEN_W-1:0] GO_LEN  = 7'd105;

    localparam int OFF_OPC  = 1;
    localparam int OFF_ACC  = 5;
    localparam int OFF_ADDR = 9;
    localparam int OFF_CNT  = 41;
    localparam int OFF_CCRC = 57;
    localparam int OFF_CST  = 89;
    localparam int OFF_CRCR = 93;
    localparam int OFF_GDAT = 5;
    localparam int OFF_GWCR = 37;
    localparam int OFF_RDAT = 37;
    localparam int OFF_GST  = 69;
    localparam int OFF_GRCR = 73;

    localparam logic [31:0] OPC_CMD  = 32'h2;
    localparam logic [31:0] ACC_RD   = 32'h6;
    localparam logic [31:0] ACC_WR   = 32'h2;
    localparam logic [31:0] BYTES_M1 = 32'h3;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD_REQ, S_CMD_WAIT, S_GO_REQ, S_GO_WAIT, S_DONE
    } seq_state_e;

    function automatic logic [FRAME_W-1:0] put_rev(input logic [FRAME_W-1:0] f,
                                                   input int off, input int w,
                                                   input logic [31:0] v);
        logic [FRAME_W-1:0] r;
        r = f;
        for (int k = 0; k < 32; k++)
            if (k < w) r[off+k] = v[w-1-k];
        return r;
    endfunction

    function automatic logic [31:0] get_rev(input logic [FRAME_W-1:0] f,
                                            input int off, input int w);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 32; k++)
            if (k < w) r[w-1-k] = f[off+k];
        return r;
    endfunction

    function automatic logic [31:0] crc_span(input logic [FRAME_W-1:0] f,
                                             input int off, input int n);
        logic [31:0] c;
        logic        fb;
        c = '1;
        for (int i = 0; i < FRAME_W; i++) begin
            if (i >= off && i < off + n) begin
                fb = f[i] ^ c[31];
                c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/dbgw_frame_build.sv
module dbgw_frame_build
    import dbgw_pkg::*;
(
    input  logic                 go_phase,
    input  logic                 wr,
    input  logic [WORD_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [FRAME_W-1:0]   frame,
    output logic [LEN_W-1:0]     len
);
    logic [31:0] crc_v;

    always_comb begin
        frame = '0;
        crc_v = '0;
        if (!go_phase) begin
            frame = put_rev(frame, OFF_OPC, 4, OPC_CMD);
            frame = put_rev(frame, OFF_ACC, 4, wr ? ACC_WR : ACC_RD);
            frame = put_rev(frame, OFF_ADDR, WORD_W, addr);
            frame = put_rev(frame, OFF_CNT, 16, BYTES_M1);
            crc_v = crc_span(frame, 0, OFF_CCRC);
            frame = put_rev(frame, OFF_CCRC, 32, crc_v);
            len   = CMD_LEN;
        end else begin
            if (wr) begin
                frame = put_rev(frame, OFF_GDAT, WORD_W, wdata);
                crc_v = crc_span(frame, 0, OFF_GWCR);
                frame = put_rev(frame, OFF_GWCR, 32, crc_v);
            end else begin
                crc_v = crc_span(frame, 0, OFF_GDAT);
                frame = put_rev(frame, OFF_GDAT, 32, crc_v);
            end
            len = GO_LEN;
        end
    end
endmodule

// File: rtl/dbgw_reply_check.sv
module dbgw_reply_check
    import dbgw_pkg::*;
(
    input  logic                 go_phase,
    input  logic                 wr,
    input  logic [FRAME_W-1:0]   reply,
    output logic                 ok,
    output logic                 stat_bad,
    output logic [WORD_W-1:0]    data
);
    logic [3:0]  stat;
    logic [31:0] crc_rx;
    logic [31:0] crc_calc;

    always_comb begin
        data = '0;
        if (!go_phase) begin
            stat     = reply[OFF_CST +: 4];
            crc_rx   = get_rev(reply, OFF_CRCR, 32);
            crc_calc = crc_span(reply, OFF_CST, 4);
        end else if (wr) begin
            stat     = reply[OFF_GST +: 4];
            crc_rx   = get_rev(reply, OFF_GRCR, 32);
            crc_calc = crc_span(reply, OFF_GST, 4);
        end else begin
            stat     = get_rev(reply, OFF_GST, 4)[3:0];
            crc_rx   = get_rev(reply, OFF_GRCR, 32);
            crc_calc = crc_span(reply, OFF_RDAT, WORD_W + 4);
            data     = get_rev(reply, OFF_RDAT, WORD_W);
        end
        stat_bad = (stat != 4'h0);
        ok       = !stat_bad && (crc_rx == crc_calc);
    end
endmodule

// File: rtl/dbgw_seq.sv
module dbgw_seq
    import dbgw_pkg::*;
#(
    parameter int MAX_TRIES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_write,
    input  logic [WORD_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output logic                 done,
    output logic                 error,
    output logic                 scan_valid,
    input  logic                 scan_ready,
    output logic [FRAME_W-1:0]   scan_frame,
    output logic [LEN_W-1:0]     scan_len,
    input  logic                 scan_done,
    input  logic [FRAME_W-1:0]   scan_reply
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_state_e        state_q, state_d;
    logic [TRY_W-1:0]  tries_q;
    logic              wr_q;
    logic [WORD_W-1:0] addr_q, wdata_q, rdata_q;
    logic              err_q;
    logic              rep_ok, rep_stat_bad, rep_abort, last_try;
    logic [WORD_W-1:0] rep_data;

    dbgw_frame_build u_build (
        .go_phase (state_q == S_GO_REQ),
        .wr       (wr_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .frame    (scan_frame),
        .len      (scan_len)
    );

    dbgw_reply_check u_check (
        .go_phase (state_q == S_GO_WAIT),
        .wr       (wr_q),
        .reply    (scan_reply),
        .ok       (rep_ok),
        .stat_bad (rep_stat_bad),
        .data     (rep_data)
    );

    assign rep_abort = !wr_q && rep_stat_bad;
    assign last_try  = (tries_q == TRY_W'(MAX_TRIES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_CMD_REQ;
            S_CMD_REQ:  if (scan_ready) state_d = S_CMD_WAIT;
            S_CMD_WAIT: if (scan_done) begin
                            if (rep_ok)        state_d = S_GO_REQ;
                            else if (last_try) state_d = S_DONE;
                            else               state_d = S_CMD_REQ;
                        end
            S_GO_REQ:   if (scan_ready) state_d = S_GO_WAIT;
            S_GO_WAIT:  if (scan_done) begin
                            if (rep_ok || rep_abort || last_try) state_d = S_DONE;
                            else                                 state_d = S_GO_REQ;
                        end
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tries_q <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                wr_q    <= is_write;
                addr_q  <= addr;
                wdata_q <= wdata;
                rdata_q <= '0;
                err_q   <= 1'b0;
                tries_q <= '0;
            end
            if (state_q == S_CMD_WAIT && scan_done) begin
                if (rep_ok)        tries_q <= '0;
                else if (last_try) err_q   <= 1'b1;
                else               tries_q <= tries_q + 1'b1;
            end
            if (state_q == S_GO_WAIT && scan_done) begin
                if (rep_ok) begin
                    if (!wr_q) rdata_q <= rep_data;
                end else if (rep_abort) begin
                    err_q   <= 1'b1;
                    rdata_q <= '0;
                end else if (last_try) begin
                    err_q <= 1'b1;
                end else begin
                    tries_q <= tries_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        scan_valid = (state_q == S_CMD_REQ) || (state_q == S_GO_REQ);
        done       = (state_q == S_DONE);
        rdata      = rdata_q;
        error      = err_q;
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid && !scan_ready |=> scan_valid && $stable(scan_frame) && $stable(scan_len)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TRY_W'(MAX_TRIES)); // R8
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && error |-> rdata == '0); // R6
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> (scan_len == CMD_LEN) || (scan_len == GO_LEN)); // R2
    AST_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) && start |=> $stable(addr_q) && $stable(wr_q)); // R11
endmodule

// File: tb/dbgw_seq_bench.sv
module dbgw_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_write = 1'b0;
    logic [31:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         done, error, scan_valid;
    logic         scan_ready = 1'b0;
    logic [127:0] scan_frame;
    logic [6:0]   scan_len;
    logic         scan_done = 1'b0;
    logic [127:0] scan_reply = '0;

    always #2 clk = ~clk;

    dbgw_seq #(.MAX_TRIES(4)) u_dbgw_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
        .addr(addr), .wdata(wdata), .rdata(rdata), .done(done), .error(error),
        .scan_valid(scan_valid), .scan_ready(scan_ready), .scan_frame(scan_frame),
        .scan_len(scan_len), .scan_done(scan_done), .scan_reply(scan_reply)
    );

    int checks = 0;
    int fails  = 0;
    int n_cmd  = 0;
    int n_go   = 0;
    int inj_cmd_stat = 0, inj_cmd_crc = 0, inj_go_stat = 0, inj_go_crc = 0;
    logic        cur_wr = 1'b0;
    logic [31:0] cur_addr = '0, cur_wdata = '0;

    typedef struct {
        logic [31:0] rd;
        logic        err;
        int          ncmd;
        int          ngo;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] fput(input logic [127:0] f, input int off,
                                          input int w, input logic [31:0] v);
        logic [127:0] r = f;
        for (int k = 0; k < w; k++) r[off+k] = v[w-1-k];
        return r;
    endfunction

    function automatic logic [31:0] fcrc(input logic [127:0] f, input int off, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = off; i < off + n; i++) begin
            if (f[i] ^ c[31]) c = (c << 1) ^ 32'h04C1_1DB7;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
    endfunction

    // scan port model: one back-pressure cycle, frame checks, fault injection
    initial begin
        forever begin
            @(negedge clk);
            if (scan_valid) begin
                logic [127:0] f0, e, r;
                logic [6:0]   l0;
                f0 = scan_frame;
                l0 = scan_len;
                @(negedge clk);
                chk(scan_valid && scan_frame == f0 && scan_len == l0, "R9 hold", scan_frame, f0);
                scan_ready = 1'b1;
                @(negedge clk);
                scan_ready = 1'b0;
                r = '0;
                if (l0 == 7'd125) begin
                    n_cmd++;
                    e = '0;
                    e = fput(e, 1, 4, 32'h2);
                    e = fput(e, 5, 4, cur_wr ? 32'h2 : 32'h6);
                    e = fput(e, 9, 32, cur_addr);
                    e = fput(e, 41, 16, 32'h3);
                    e = fput(e, 57, 32, fcrc(e, 0, 57));
                    chk(f0 == e, "R2 cmd frame", f0, e);
                    if (inj_cmd_stat > 0) begin r[89] = 1'b1; inj_cmd_stat--; end
                    r = fput(r, 93, 32, fcrc(r, 89, 4));
                    if (r[89] == 1'b0 && inj_cmd_crc > 0) begin r[100] = ~r[100]; inj_cmd_crc--; end
                end else begin
                    n_go++;
                    e = '0;
                    if (cur_wr) begin
                        e = fput(e, 5, 32, cur_wdata);
                        e = fput(e, 37, 32, fcrc(e, 0, 37));
                    end else begin
                        e = fput(e, 5, 32, fcrc(e, 0, 5));
                    end
                    chk(f0 == e && l0 == 7'd105, "R3 go frame", f0, e);
                    if (cur_wr) begin
                        if (inj_go_stat > 0) begin r[70] = 1'b1; inj_go_stat--; end
                        r = fput(r, 73, 32, fcrc(r, 69, 4));
                    end else begin
                        r = fput(r, 37, 32, mem_val(cur_addr));
                        if (inj_go_stat > 0) begin r = fput(r, 69, 4, 32'h2); inj_go_stat--; end
                        r = fput(r, 73, 32, fcrc(r, 37, 36));
                    end
                    if (inj_go_crc > 0) begin r[80] = ~r[80]; inj_go_crc--; end
                end
                repeat (2) @(negedge clk);
                scan_reply = r;
                scan_done  = 1'b1;
                @(negedge clk);
                scan_done  = 1'b0;
                scan_reply = '0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 128'(1), 128'(0));
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk(rdata == x.rd, {x.tag, " rdata"}, 128'(rdata), 128'(x.rd));
                    chk(error == x.err, {x.tag, " error"}, 128'(error), 128'(x.err));
                    chk(n_cmd == x.ncmd, {x.tag, " cmd attempts"}, 128'(n_cmd), 128'(x.ncmd));
                    chk(n_go == x.ngo, {x.tag, " go attempts"}, 128'(n_go), 128'(x.ngo));
                end
            end
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk(!done, "R10 single pulse", 128'(done), 128'(0));
    endtask

    task automatic run_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input logic exp_err,
                          input int ncmd, input int ngo, input string tag);
        exp_t x;
        x.rd = exp_rd; x.err = exp_err; x.ncmd = ncmd; x.ngo = ngo; x.tag = tag;
        sb.push_back(x);
        n_cmd = 0; n_go = 0;
        cur_wr = wr; cur_addr = a; cur_wdata = d;
        is_write = wr; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !error && !scan_valid && rdata == '0, "R1 reset", 128'(rdata), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scan_valid && !done, "R1 idle", 128'(scan_valid), 128'(0));

        run_op(1'b0, 32'h8000_1234, '0, mem_val(32'h8000_1234), 1'b0, 1, 1, "R5 read");
        run_op(1'b1, 32'h0000_0FF0, 32'hDEAD_BEEF, '0, 1'b0, 1, 1, "R3 write");
        run_op(1'b0, 32'hFFFF_FFFC, '0, mem_val(32'hFFFF_FFFC), 1'b0, 1, 1, "R5 read ones");

        inj_cmd_stat = 1; inj_cmd_crc = 1;
        run_op(1'b0, 32'h1357_9BDF, '0, mem_val(32'h1357_9BDF), 1'b0, 3, 1, "R4 cmd retry");

        inj_go_stat = 1;
        run_op(1'b1, 32'h2468_ACE0, 32'h0123_4567, '0, 1'b0, 1, 2, "R7 write status retry");

        inj_go_crc = 2;
        run_op(1'b1, 32'h0000_0004, 32'hA5A5_5A5A, '0, 1'b0, 1, 3, "R7 write crc retry");

        inj_go_crc = 3;
        run_op(1'b0, 32'h4000_0000, '0, mem_val(32'h4000_0000), 1'b0, 1, 4, "R5 read crc retry");

        inj_cmd_crc = 4;
        run_op(1'b0, 32'h7777_0000, '0, '0, 1'b1, 4, 0, "R8 cmd limit");

        inj_go_crc = 4;
        run_op(1'b1, 32'h7777_0004, 32'h1111_2222, '0, 1'b1, 1, 4, "R8 go limit");

        inj_go_stat = 1;
        run_op(1'b0, 32'h0BAD_0000, '0, '0, 1'b1, 1, 1, "R6 read abort");

        // R11: second start while busy must not change the access
        begin
            exp_t x;
            x.rd = mem_val(32'hC0DE_0010); x.err = 1'b0; x.ncmd = 3; x.ngo = 1;
            x.tag = "R11 busy start";
            sb.push_back(x);
            n_cmd = 0; n_go = 0; inj_cmd_crc = 2;
            cur_wr = 1'b0; cur_addr = 32'hC0DE_0010; cur_wdata = '0;
            is_write = 1'b0; addr = 32'hC0DE_0010; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            is_write = 1'b1; addr = 32'h9999_9999; wdata = 32'h5555_AAAA; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            repeat (30) @(negedge clk);
            chk(n_cmd == 3 && !scan_valid, "R11 no extra access", 128'(n_cmd), 128'(3));
        end

        chk(sb.size() == 0, "R10 one done per request", 128'(sb.size()), 128'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule